// File: doc/BRIEF.md
# Capability CSR Access Unit

This block carries out control-register read/modify/write operations against a small register file. The file holds two kinds of entries: plain 32-bit registers and capability registers, each of which is a 64-bit value plus a separate validity tag. A capability register can be reached through a narrow (32-bit) view or a wide (64-bit plus tag) view. The narrow view exposes only the address field.

Each operation arrives already decoded. It is a write, a bit-set or a bit-clear, in register-source or 5-bit-immediate form. The operation also carries a register index, a view selector, flags saying whether the source or destination register is the zero register, and a permission bit. The old value appears combinationally on the read outputs. The new value is committed on the next rising clock edge.

Set, clear and all narrow or immediate writes change only the address of a capability. The tag survives such a change only if the capability is unsealed and the new address is still representable. A full wide write replaces the whole capability, including its tag.

Top module: `cap_csr_unit`

## Requirements
- R1: After reset, every register reads as zero and every capability tag reads as clear.
- R2: A register-form write (op 3'b000) through the wide view (view=1) to a capability register stores all 64 source bits and the source tag, and returns the previous 64-bit value and tag.
- R3: Through the narrow view (view=0), a capability read returns its address (bits 31:0) zero-extended, with the output tag 0. A narrow register-form write replaces only the address with source bits 31:0.
- R4: Set (op 3'b001) forms new address = old | operand. Clear (op 3'b010) forms new address = old & ~operand. Bits 63:32 of the capability stay unchanged, whichever view is used.
- R5: Immediate forms (op 3'b100 write, 3'b101 set, 3'b110 clear) use the 5-bit immediate zero-extended to 32 bits as the operand.
- R6: An address-only update clears the tag when the object type (bits 35:32) is nonzero, meaning the capability is sealed.
- R7: An address-only update keeps the tag only if the new address A satisfies base-4096 <= A < top+4096. Here base = bits 47:36 shifted left by 20 and top = bits 59:48 shifted left by 20. Otherwise the tag is cleared.
- R8: Set or clear with rs_zero=1, or an immediate set or clear with immediate 0, does not write: the write strobe is 0, the state is unchanged and the tag is not re-checked. The read still happens.
- R9: Write or immediate write with rd_zero=1 does not read: the read strobe is 0 and the read outputs are 0. The write still happens.
- R10: Registers 1 and 3 are privileged. Accessing them with perm_ok=0 raises the fault output, drives both strobes low, and leaves all state unchanged.
- R11: Plain registers (0 and 1) follow 32-bit write/set/clear rules. They ignore the source tag and source bits 63:32, and always read with the upper 32 bits and the tag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 3 | Bit 2 immediate form; bits 1:0 00 write, 01 set, 10 clear |
| csr_idx | input | 2 | Register index; 0,1 plain, 2,3 capability |
| wide_view | input | 1 | 1 selects the 64-bit view of a capability register |
| src_data | input | 64 | Source operand |
| src_tag | input | 1 | Source tag, used by wide register-form writes |
| imm5 | input | 5 | Unsigned immediate |
| rd_zero | input | 1 | Destination is the zero register |
| rs_zero | input | 1 | Source is the zero register |
| perm_ok | input | 1 | Caller may access privileged registers |
| rd_data | output | 64 | Previous register value |
| rd_tag | output | 1 | Previous tag (wide view only) |
| rd_strobe | output | 1 | A read with side effects takes place |
| wr_strobe | output | 1 | A write is committed at the next edge |
| priv_fault | output | 1 | Privilege violation |

## Verification
The bench places addresses exactly on both edges of the representable window: one below the top limit, at the top limit, at the lower limit, and one below it. An off-by-one comparison or a window that misses the slack would keep or drop the tag on the wrong side. A sealed capability is updated inside its window, so a design that ignores the object type would keep the tag. Zero-source set and clear operations are run on a sealed, tagged capability, so a design that still writes would strobe and clear the tag. Zero-destination writes must show no read yet still commit, and an ungranted privileged write must leave the register readable as its old zero value.

// File: rtl/cap_csr_pkg.sv
package cap_csr_pkg;
  localparam int XLEN      = 32;
  localparam int CLEN      = 64;
  localparam int SLACK     = 4096;
  localparam int BND_SHIFT = 20;

  localparam logic [2:0] OP_RW  = 3'b000;
  localparam logic [2:0] OP_RS  = 3'b001;
  localparam logic [2:0] OP_RC  = 3'b010;
  localparam logic [2:0] OP_RWI = 3'b100;
  localparam logic [2:0] OP_RSI = 3'b101;
  localparam logic [2:0] OP_RCI = 3'b110;

  typedef enum logic [1:0] {FN_WRITE = 2'b00, FN_SET = 2'b01, FN_CLEAR = 2'b10} csr_fn_e;

  typedef struct packed {
    logic [3:0]  perms;
    logic [11:0] top;
    logic [11:0] base;
    logic [3:0]  otype;
    logic [31:0] addr;
  } cap_t;
endpackage

// File: rtl/cap_csr_decode.sv
module cap_csr_decode
  import cap_csr_pkg::*;
#(
  parameter int NUM_PLAIN = 2,
  parameter int NUM_CAP = 2,
  parameter logic [31:0] PRIV_MASK = 32'h0000_000A,
  localparam int NUM_CSR = NUM_PLAIN + NUM_CAP,
  localparam int IDXW = (NUM_CSR > 1) ? $clog2(NUM_CSR) : 1
) (
  input  logic            op_valid,
  input  logic [2:0]      op_kind,
  input  logic [IDXW-1:0] csr_idx,
  input  logic [4:0]      imm5,
  input  logic            rd_zero,
  input  logic            rs_zero,
  input  logic            perm_ok,
  output logic            rd_en,
  output logic            wr_en,
  output logic            fault,
  output logic            is_cap,
  output logic            is_imm,
  output csr_fn_e         fn
);
  logic legal_op, in_range, go, src_zero, is_write;

  always_comb begin
    unique case (op_kind)
      OP_RW, OP_RS, OP_RC, OP_RWI, OP_RSI, OP_RCI: legal_op = 1'b1;
      default:                                     legal_op = 1'b0;
    endcase
  end

  assign in_range = int'(csr_idx) < NUM_CSR;
  assign is_cap   = int'(csr_idx) >= NUM_PLAIN;
  assign is_imm   = op_kind[2];
  assign fn       = csr_fn_e'(op_kind[1:0]);
  assign fault    = op_valid && legal_op && in_range && PRIV_MASK[csr_idx] && !perm_ok;
  assign go       = op_valid && legal_op && in_range && !fault;
  assign src_zero = is_imm ? (imm5 == 5'd0) : rs_zero;
  assign is_write = (fn == FN_WRITE);
  assign wr_en    = go && (is_write || !src_zero);
  assign rd_en    = go && !(is_write && rd_zero);
endmodule

// File: rtl/cap_csr_addr_update.sv
module cap_csr_addr_update
  import cap_csr_pkg::*;
(
  input  logic [CLEN-1:0] cur_val,
  input  logic            cur_tag,
  input  csr_fn_e         fn,
  input  logic            is_imm,
  input  logic            is_cap,
  input  logic            wide_view,
  input  logic [CLEN-1:0] src_data,
  input  logic            src_tag,
  input  logic [4:0]      imm5,
  output logic [CLEN-1:0] new_val,
  output logic            new_tag,
  output logic            addr_only
);
  cap_t               cur, upd;
  logic [XLEN-1:0]    operand, new_addr;
  logic               full_wr, sealed, repr;
  logic signed [33:0] lo_lim, hi_lim, addr_ext;

  assign cur     = cap_t'(cur_val);
  assign operand = is_imm ? {{(XLEN-5){1'b0}}, imm5} : src_data[XLEN-1:0];

  always_comb begin
    unique case (fn)
      FN_SET:   new_addr = cur.addr | operand;
      FN_CLEAR: new_addr = cur.addr & ~operand;
      default:  new_addr = operand;
    endcase
  end

  assign lo_lim   = $signed({2'b00, cur.base, {BND_SHIFT{1'b0}}}) - 34'sd4096;
  assign hi_lim   = $signed({2'b00, cur.top,  {BND_SHIFT{1'b0}}}) + 34'sd4096;
  assign addr_ext = $signed({2'b00, new_addr});
  assign repr     = (addr_ext >= lo_lim) && (addr_ext < hi_lim);
  assign sealed   = (cur.otype != 4'd0);

  assign full_wr   = is_cap && wide_view && !is_imm && (fn == FN_WRITE);
  assign addr_only = is_cap && !full_wr;

  always_comb begin
    upd      = cur;
    upd.addr = new_addr;
    if (full_wr) begin
      new_val = src_data;
      new_tag = src_tag;
    end else begin
      new_val = upd;
      new_tag = cur_tag && !sealed && repr && is_cap;
    end
  end
endmodule

// File: rtl/cap_csr_file.sv
module cap_csr_file
  import cap_csr_pkg::*;
#(
  parameter int NUM_PLAIN = 2,
  parameter int NUM_CAP = 2,
  localparam int NUM_CSR = NUM_PLAIN + NUM_CAP,
  localparam int IDXW = (NUM_CSR > 1) ? $clog2(NUM_CSR) : 1,
  localparam int PIW = (NUM_PLAIN > 1) ? $clog2(NUM_PLAIN) : 1,
  localparam int CIW = (NUM_CAP > 1) ? $clog2(NUM_CAP) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] csr_idx,
  input  logic            is_cap,
  input  logic            wr_en,
  input  logic            addr_only,
  input  logic            fault,
  input  logic [CLEN-1:0] new_val,
  input  logic            new_tag,
  output logic [CLEN-1:0] cur_val,
  output logic            cur_tag
);
  logic [IDXW-1:0]          cap_off;
  logic [PIW-1:0]           pidx;
  logic [CIW-1:0]           cidx;
  logic [NUM_PLAIN*XLEN-1:0] plain_flat;
  logic [NUM_CAP*CLEN-1:0]   cap_flat;
  logic [NUM_CAP-1:0]        tag_flat;

  assign cap_off = csr_idx - IDXW'(NUM_PLAIN);
  assign pidx    = PIW'(csr_idx);
  assign cidx    = CIW'(cap_off);

  for (genvar p = 0; p < NUM_PLAIN; p++) begin : g_plain
    logic [XLEN-1:0] val_q, val_d;
    logic            en;
    assign en = wr_en && !is_cap && (pidx == PIW'(p));
    always_comb val_d = en ? new_val[XLEN-1:0] : val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end
    assign plain_flat[p*XLEN +: XLEN] = val_q;
  end

  for (genvar c = 0; c < NUM_CAP; c++) begin : g_cap
    logic [CLEN-1:0] val_q, val_d;
    logic            tag_q, tag_d, en;
    assign en = wr_en && is_cap && (cidx == CIW'(c));
    always_comb begin
      val_d = en ? new_val : val_q;
      tag_d = en ? new_tag : tag_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
        tag_q <= 1'b0;
      end else begin
        val_q <= val_d;
        tag_q <= tag_d;
      end
    end
    assign cap_flat[c*CLEN +: CLEN] = val_q;
    assign tag_flat[c] = tag_q;
  end

  always_comb begin
    if (is_cap) begin
      cur_val = cap_flat[CLEN*int'(cidx) +: CLEN];
      cur_tag = tag_flat[cidx];
    end else begin
      cur_val = {{(CLEN-XLEN){1'b0}}, plain_flat[XLEN*int'(pidx) +: XLEN]};
      cur_tag = 1'b0;
    end
  end

  AST_FAULT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> ($stable(plain_flat) && $stable(cap_flat) && $stable(tag_flat))); // R10

  AST_META_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_only && is_cap) |=>
      (cap_flat[CLEN*int'($past(cidx)) + XLEN +: XLEN] ==
       $past(cap_flat[CLEN*int'(cidx) + XLEN +: XLEN]))); // R4

  AST_TAG_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_only && is_cap) |=>
      !(tag_flat[$past(cidx)] && !$past(tag_flat[cidx]))); // R6
endmodule

// File: rtl/cap_csr_unit.sv
module cap_csr_unit
  import cap_csr_pkg::*;
#(
  parameter int NUM_PLAIN = 2,
  parameter int NUM_CAP = 2,
  parameter logic [31:0] PRIV_MASK = 32'h0000_000A,
  localparam int NUM_CSR = NUM_PLAIN + NUM_CAP,
  localparam int IDXW = (NUM_CSR > 1) ? $clog2(NUM_CSR) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [2:0]      op_kind,
  input  logic [IDXW-1:0] csr_idx,
  input  logic            wide_view,
  input  logic [63:0]     src_data,
  input  logic            src_tag,
  input  logic [4:0]      imm5,
  input  logic            rd_zero,
  input  logic            rs_zero,
  input  logic            perm_ok,
  output logic [63:0]     rd_data,
  output logic            rd_tag,
  output logic            rd_strobe,
  output logic            wr_strobe,
  output logic            priv_fault
);
  logic [1:0]      rst_pipe;
  logic            rst_int;
  logic            rd_en, wr_en, fault, is_cap, is_imm, addr_only;
  csr_fn_e         fn;
  logic [CLEN-1:0] cur_val, new_val;
  logic            cur_tag, new_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  cap_csr_decode #(.NUM_PLAIN(NUM_PLAIN), .NUM_CAP(NUM_CAP), .PRIV_MASK(PRIV_MASK)) u_dec (
    .op_valid(op_valid), .op_kind(op_kind), .csr_idx(csr_idx), .imm5(imm5),
    .rd_zero(rd_zero), .rs_zero(rs_zero), .perm_ok(perm_ok),
    .rd_en(rd_en), .wr_en(wr_en), .fault(fault), .is_cap(is_cap),
    .is_imm(is_imm), .fn(fn)
  );

  cap_csr_file #(.NUM_PLAIN(NUM_PLAIN), .NUM_CAP(NUM_CAP)) u_file (
    .clk(clk), .rst_n(rst_int), .csr_idx(csr_idx), .is_cap(is_cap),
    .wr_en(wr_en), .addr_only(addr_only), .fault(fault),
    .new_val(new_val), .new_tag(new_tag), .cur_val(cur_val), .cur_tag(cur_tag)
  );

  cap_csr_addr_update u_upd (
    .cur_val(cur_val), .cur_tag(cur_tag), .fn(fn), .is_imm(is_imm),
    .is_cap(is_cap), .wide_view(wide_view), .src_data(src_data),
    .src_tag(src_tag), .imm5(imm5), .new_val(new_val), .new_tag(new_tag),
    .addr_only(addr_only)
  );

  always_comb begin
    rd_data = '0;
    rd_tag  = 1'b0;
    if (rd_en) begin
      if (is_cap && wide_view) begin
        rd_data = cur_val;
        rd_tag  = cur_tag;
      end else begin
        rd_data = {{(CLEN-XLEN){1'b0}}, cur_val[XLEN-1:0]};
      end
    end
  end

  assign rd_strobe  = rd_en;
  assign wr_strobe  = wr_en;
  assign priv_fault = fault;

  AST_ZERO_SRC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_int)
    (op_valid && (op_kind == OP_RS || op_kind == OP_RC) && rs_zero) |-> !wr_strobe); // R8

  AST_ZERO_DST_NO_READ: assert property (@(posedge clk) disable iff (!rst_int)
    (op_valid && (op_kind == OP_RW || op_kind == OP_RWI) && rd_zero) |->
      (!rd_strobe && rd_data == 64'd0 && !rd_tag)); // R9

  AST_NARROW_NO_TAG: assert property (@(posedge clk) disable iff (!rst_int)
    !wide_view |-> !rd_tag); // R3

  AST_FAULT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_int)
    priv_fault |-> (!wr_strobe && !rd_strobe)); // R10
endmodule

// File: tb/cap_csr_unit_test.sv
module cap_csr_unit_test;
  logic        clk, rst_n, op_valid, wide_view, src_tag, rd_zero, rs_zero, perm_ok;
  logic [2:0]  op_kind;
  logic [1:0]  csr_idx;
  logic [63:0] src_data, rd_data;
  logic [4:0]  imm5;
  logic        rd_tag, rd_strobe, wr_strobe, priv_fault;

  int n_checks = 0;
  int n_fail = 0;
  logic [63:0] g_data;
  logic g_tag, g_rd, g_wr, g_fault;

  cap_csr_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .csr_idx(csr_idx), .wide_view(wide_view), .src_data(src_data),
    .src_tag(src_tag), .imm5(imm5), .rd_zero(rd_zero), .rs_zero(rs_zero),
    .perm_ok(perm_ok), .rd_data(rd_data), .rd_tag(rd_tag),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .priv_fault(priv_fault)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [63:0] mk(input logic [11:0] top, input logic [11:0] base,
                                     input logic [3:0] ot, input logic [31:0] a);
    return {4'h0, top, base, ot, a};
  endfunction

  task automatic chk(input string req, input logic [64:0] act, input logic [64:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] k, input logic [1:0] idx, input logic wv,
                        input logic [63:0] s, input logic st, input logic [4:0] im,
                        input logic rdz, input logic rsz, input logic pok);
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; csr_idx = idx; wide_view = wv; src_data = s;
    src_tag = st; imm5 = im; rd_zero = rdz; rs_zero = rsz; perm_ok = pok;
    #1;
    g_data = rd_data; g_tag = rd_tag; g_rd = rd_strobe; g_wr = wr_strobe; g_fault = priv_fault;
    @(posedge clk);
    #1 op_valid = 1'b0;
  endtask

  task automatic rd_csr(input logic [1:0] idx, input logic wv);
    run_op(3'b001, idx, wv, 64'd0, 1'b0, 5'd0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic full_wr(input logic [63:0] v, input logic t);
    run_op(3'b000, 2'd2, 1'b1, v, t, 5'd0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) begin
      rd_csr(i[1:0], 1'b1);
      chk("R1 reset value", {g_tag, g_data}, 65'd0);
      chk("R8 zero-source read does not write", {64'd0, g_wr}, 65'd0);
    end
  endtask

  task automatic t_wide_write;
    full_wr(mk(12'd2, 12'd1, 4'd0, 32'h0015_0000), 1'b1);
    chk("R2 returns old value", {g_tag, g_data}, 65'd0);
    chk("R2 write strobe", {64'd0, g_wr}, 65'd1);
    rd_csr(2'd2, 1'b1);
    chk("R2 stored capability", {g_tag, g_data}, {1'b1, mk(12'd2, 12'd1, 4'd0, 32'h0015_0000)});
  endtask

  task automatic t_narrow;
    rd_csr(2'd2, 1'b0);
    chk("R3 narrow read", {g_tag, g_data}, {1'b0, 64'h0000_0000_0015_0000});
    run_op(3'b000, 2'd2, 1'b0, 64'hFFFF_FFFF_0018_0000, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1);
    chk("R3 narrow write returns address", {g_tag, g_data}, {1'b0, 64'h0000_0000_0015_0000});
    rd_csr(2'd2, 1'b1);
    chk("R3 narrow write address only", {g_tag, g_data}, {1'b1, mk(12'd2, 12'd1, 4'd0, 32'h0018_0000)});
  endtask

  task automatic t_set_clear;
    run_op(3'b001, 2'd2, 1'b0, 64'h0000_0000_0000_0F00, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1);
    rd_csr(2'd2, 1'b1);
    chk("R4 set", {g_tag, g_data}, {1'b1, mk(12'd2, 12'd1, 4'd0, 32'h0018_0F00)});
    run_op(3'b010, 2'd2, 1'b1, 64'hFFFF_FFFF_0000_0F00, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1);
    chk("R4 clear returns full value", {g_tag, g_data}, {1'b1, mk(12'd2, 12'd1, 4'd0, 32'h0018_0F00)});
    rd_csr(2'd2, 1'b1);
    chk("R4 clear", {g_tag, g_data}, {1'b1, mk(12'd2, 12'd1, 4'd0, 32'h0018_0000)});
  endtask

  task automatic t_imm;
    run_op(3'b101, 2'd2, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 5'h13, 1'b0, 1'b0, 1'b1);
    rd_csr(2'd2, 1'b1);
    chk("R5 immediate set", {g_tag, g_data}, {1'b1, mk(12'd2, 12'd1, 4'd0, 32'h0018_0013)});
    run_op(3'b110, 2'd2, 1'b0, 64'd0, 1'b0, 5'h03, 1'b0, 1'b0, 1'b1);
    rd_csr(2'd2, 1'b1);
    chk("R5 immediate clear", {g_tag, g_data}, {1'b1, mk(12'd2, 12'd1, 4'd0, 32'h0018_0010)});
  endtask

  task automatic t_window;
    full_wr(mk(12'd2, 12'd1, 4'd0, 32'h0020_0000), 1'b1);
    run_op(3'b001, 2'd2, 1'b0, 64'h0FFF, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1);
    rd_csr(2'd2, 1'b1);
    chk("R7 just below upper limit", {g_tag, g_data}, {1'b1, mk(12'd2, 12'd1, 4'd0, 32'h0020_0FFF)});
    full_wr(mk(12'd2, 12'd1, 4'd0, 32'h0020_0000), 1'b1);
    run_op(3'b001, 2'd2, 1'b0, 64'h1000, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1);
    rd_csr(2'd2, 1'b1);
    chk("R7 at upper limit", {g_tag, g_data}, {1'b0, mk(12'd2, 12'd1, 4'd0, 32'h0020_1000)});
    full_wr(mk(12'd2, 12'd1, 4'd0, 32'h000F_F000), 1'b1);
    run_op(3'b001, 2'd2, 1'b0, 64'h0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1);
    chk("R7 nonzero register with zero value writes", {64'd0, g_wr}, 65'd1);
    rd_csr(2'd2, 1'b1);
    chk("R7 at lower limit", {g_tag, g_data}, {1'b1, mk(12'd2, 12'd1, 4'd0, 32'h000F_F000)});
    full_wr(mk(12'd2, 12'd1, 4'd0, 32'h000F_FFFF), 1'b1);
    run_op(3'b010, 2'd2, 1'b0, 64'h1000, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1);
    rd_csr(2'd2, 1'b1);
    chk("R7 below lower limit", {g_tag, g_data}, {1'b0, mk(12'd2, 12'd1, 4'd0, 32'h000F_EFFF)});
  endtask

  task automatic t_sealed;
    full_wr(mk(12'd2, 12'd1, 4'd5, 32'h0015_0000), 1'b1);
    run_op(3'b001, 2'd2, 1'b0, 64'h4, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1);
    rd_csr(2'd2, 1'b1);
    chk("R6 sealed loses tag", {g_tag, g_data}, {1'b0, mk(12'd2, 12'd1, 4'd5, 32'h0015_0004)});
  endtask

  task automatic t_zero_src;
    full_wr(mk(12'd2, 12'd1, 4'd5, 32'h0015_0000), 1'b1);
    run_op(3'b001, 2'd2, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 5'd0, 1'b0, 1'b1, 1'b1);
    chk("R8 set zero source no strobe", {64'd0, g_wr}, 65'd0);
    chk("R8 set zero source still reads", {g_tag, g_data}, {1'b1, mk(12'd2, 12'd1, 4'd5, 32'h0015_0000)});
    run_op(3'b110, 2'd2, 1'b1, 64'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1);
    chk("R8 immediate clear zero no strobe", {64'd0, g_wr}, 65'd0);
    rd_csr(2'd2, 1'b1);
    chk("R8 state unchanged", {g_tag, g_data}, {1'b1, mk(12'd2, 12'd1, 4'd5, 32'h0015_0000)});
  endtask

  task automatic t_zero_dst;
    run_op(3'b000, 2'd2, 1'b1, mk(12'd2, 12'd1, 4'd0, 32'h0016_0000), 1'b1, 5'd0, 1'b1, 1'b0, 1'b1);
    chk("R9 no read strobe", {63'd0, g_rd, g_wr}, 65'd1);
    chk("R9 read outputs zero", {g_tag, g_data}, 65'd0);
    rd_csr(2'd2, 1'b1);
    chk("R9 write still committed", {g_tag, g_data}, {1'b1, mk(12'd2, 12'd1, 4'd0, 32'h0016_0000)});
    run_op(3'b100, 2'd2, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 5'h1F, 1'b1, 1'b0, 1'b1);
    chk("R9 immediate write no read", {63'd0, g_rd, g_wr}, 65'd1);
    rd_csr(2'd2, 1'b1);
    chk("R5 immediate write zero-extended", {g_tag, g_data}, {1'b0, mk(12'd2, 12'd1, 4'd0, 32'h0000_001F)});
  endtask

  task automatic t_priv;
    run_op(3'b000, 2'd3, 1'b1, mk(12'd2, 12'd1, 4'd0, 32'h0015_0000), 1'b1, 5'd0, 1'b0, 1'b0, 1'b0);
    chk("R10 fault on capability register", {62'd0, g_fault, g_rd, g_wr}, 65'd4);
    rd_csr(2'd3, 1'b1);
    chk("R10 capability register unchanged", {g_tag, g_data}, 65'd0);
    run_op(3'b001, 2'd1, 1'b0, 64'h5, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0);
    chk("R10 fault on plain register", {62'd0, g_fault, g_rd, g_wr}, 65'd4);
    rd_csr(2'd1, 1'b0);
    chk("R10 plain register unchanged", {g_tag, g_data}, 65'd0);
  endtask

  task automatic t_plain;
    run_op(3'b000, 2'd0, 1'b1, 64'hFFFF_FFFF_DEAD_BEEF, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0);
    chk("R11 plain write returns old", {g_tag, g_data}, 65'd0);
    rd_csr(2'd0, 1'b1);
    chk("R11 plain write 32 bits", {g_tag, g_data}, {1'b0, 64'h0000_0000_DEAD_BEEF});
    run_op(3'b001, 2'd0, 1'b0, 64'h11, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1);
    rd_csr(2'd0, 1'b0);
    chk("R11 plain set", {g_tag, g_data}, {1'b0, 64'h0000_0000_DEAD_BEFF});
    run_op(3'b010, 2'd0, 1'b0, 64'hDEAD_0000, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1);
    rd_csr(2'd0, 1'b1);
    chk("R11 plain clear", {g_tag, g_data}, {1'b0, 64'h0000_0000_0000_BEFF});
  endtask

  bit done = 1'b0;

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_kind = 3'b000; csr_idx = 2'd0; wide_view = 1'b0;
    src_data = 64'd0; src_tag = 1'b0; imm5 = 5'd0; rd_zero = 1'b0; rs_zero = 1'b0; perm_ok = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset;
    t_wide_write;
    t_narrow;
    t_set_clear;
    t_imm;
    t_window;
    t_sealed;
    t_zero_src;
    t_zero_dst;
    t_priv;
    t_plain;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule